// File: doc/BRIEF.md
# Byte ALU with Grouped Flag Writes

This block is the arithmetic and logic unit of a small 8-bit processor datapath. Two operand registers, T1 and T2, are filled from a shared operand bus. An operation issued on a later cycle combines them and registers an 8-bit result together with five status flags: sign, zero, auxiliary carry, parity and carry. Single-operand operations work on T1. Two-operand operations treat T2 as the accumulator side, so subtraction yields T2 minus T1. A sequencer drives the block one operation per cycle.

Each operation carries a flag-group code that selects which flags it writes, so one operation set can serve both flag-producing instructions and silent address arithmetic. The block also keeps a separate byte-chain carry. When the alternate carry is selected, add-with-carry and subtract-with-borrow take their carry from that chain instead of the carry flag, or from a forced 1 on the low byte. Two byte operations then make a 16-bit increment or decrement without touching the programmer-visible carry. Decimal adjust takes two back-to-back issues: the first captures the correction and the second applies it.

Top module: `alu8_flagged`

## Requirements
- R1: After reset, result is 0x00, flags is 0b00000, T1, T2 and the chain carry are 0, and no decimal adjust is pending.
- R2: On a rising edge, loadT1 and loadT2 capture opndIn into T1 and T2. clrT1 zeroes T1 and wins over loadT1. An operation issued on the same edge uses the operand values held before that edge.
- R3: Operation codes 0 to 3 are add, add-with-carry, subtract and subtract-with-borrow, giving T2+T1(+cin) and T2-T1(-cin). Carry is the carry out of bit 7, or the borrow. Auxiliary carry is the carry out of bit 3, or the borrow into bit 4. Only codes 1 and 3 use cin.
- R4: Codes 4, 5 and 6 give T2 AND, XOR and OR T1, with carry and auxiliary carry computed as 0. Code 7 gives NOT T1 and code 15 passes T1. Both keep the current carry and compute auxiliary carry as 0.
- R5: Codes 9 to 12 rotate T1 left circular, right circular, left through carry and right through carry. The bit shifted out becomes the new carry.
- R6: The flags port holds sign in bit 4, zero in bit 3, auxiliary carry in bit 2, parity in bit 1 and carry in bit 0. Sign is result bit 7. Zero is set when all result bits are 0. Parity is set when the result has an even number of ones.
- R7: flagGrp 0 writes no flag. 1 writes every flag except carry. 2 writes only carry. 3 writes all flags.
- R8: Code 13 inverts the carry flag and code 14 sets it, whatever the flag group. Both leave the result and the other four flags unchanged.
- R9: With useAux high, codes 0 to 3 write their carry or borrow out into the chain carry. Codes 1 and 3 then take cin from the chain carry, or a constant 1 when setAux is also high. With useAux low, cin is the carry flag. setAux has no effect without useAux.
- R10: Code 8 (decimal adjust) first issues store a correction and return T1 unchanged with no flag write. An immediately following code 8 issue adds the correction (0x06 if the low digit exceeds 9 or auxiliary carry is set; 0x60 if the high digit exceeds 9, carry is set, or the high digit is 9 while the low digit exceeds 9). Its carry is the old carry OR the high correction. Any other issued operation cancels the pending state.
- R11: While opValid is low, result and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| opndIn | input | 8 | Shared operand bus for T1 and T2 |
| loadT1 | input | 1 | Capture opndIn into T1 |
| loadT2 | input | 1 | Capture opndIn into T2 |
| clrT1 | input | 1 | Zero T1 (priority over loadT1) |
| opValid | input | 1 | Issue an operation this cycle |
| opCode | input | 4 | Operation code |
| flagGrp | input | 2 | Flag-write group |
| useAux | input | 1 | Take carry-in from the chain carry |
| setAux | input | 1 | Force the chain carry-in to 1 |
| result | output | 8 | Registered result |
| flags | output | 5 | Registered S, Z, AC, P, CY |

## Verification
The assertions assume that opCode and flagGrp carry known values whenever opValid is high, and that reset is applied before the first issue. The flag-consistency property also excludes decimal adjust, because its first issue deliberately writes no flag and the property sees only ports. The bench drives every control at the falling edge. It raises setAux only together with useAux and always issues decimal adjust in the paired pattern it expects. It also cancels a pending adjust on purpose, to show that the cancelled state returns to the first phase.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W  = 8;
  localparam int NIB_W   = DATA_W / 2;
  localparam int FLAG_W  = 5;
  localparam int OPC_W   = 4;
  localparam int GRP_W   = 2;

  // flag bit positions on the flags port
  localparam int F_S  = 4;
  localparam int F_Z  = 3;
  localparam int F_AC = 2;
  localparam int F_P  = 1;
  localparam int F_CY = 0;

  localparam int DIGIT_MAX = 9;
  localparam logic [DATA_W-1:0] ADJ_LO = 8'h06;
  localparam logic [DATA_W-1:0] ADJ_HI = 8'h60;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_NOT  = 4'd7,
    OP_DAA  = 4'd8,
    OP_RLC  = 4'd9,
    OP_RRC  = 4'd10,
    OP_RAL  = 4'd11,
    OP_RAR  = 4'd12,
    OP_CMC  = 4'd13,
    OP_STC  = 4'd14,
    OP_PASS = 4'd15
  } aluOp_e;

  typedef enum logic [GRP_W-1:0] {
    FG_NONE = 2'd0,
    FG_R    = 2'd1,
    FG_C    = 2'd2,
    FG_RC   = 2'd3
  } flagGrp_e;

  typedef enum logic [1:0] {
    CIN_FLAG  = 2'd0,
    CIN_CHAIN = 2'd1,
    CIN_ONE   = 2'd2
  } cinSel_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e  op;
    cinSel_e cinSel;
    logic    wrRes;
    logic    wrMain;
    logic    wrCy;
    logic    wrChain;
    logic    daaLatch;
    logic    daaApply;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [DATA_W-1:0] t1,
  input  logic [DATA_W-1:0] t2,
  input  logic              cin,
  input  logic              cyNow,
  input  logic              acNow,
  input  aluOp_e            op,
  input  logic              daaApply,
  input  logic [DATA_W-1:0] daaAdj,
  input  logic              daaCy,
  output logic [DATA_W-1:0] res,
  output logic              cyOut,
  output logic              acOut,
  output logic              sgnOut,
  output logic              zeroOut,
  output logic              parOut,
  output logic [DATA_W-1:0] corrOut,
  output logic              corrCy
);

  logic              cinEff;
  logic [DATA_W:0]   addW;
  logic [DATA_W:0]   subW;
  logic [NIB_W:0]    addN;
  logic [NIB_W:0]    subN;
  logic [DATA_W:0]   daaW;
  logic [NIB_W:0]    daaN;
  logic [NIB_W-1:0]  loDig;
  logic [NIB_W-1:0]  hiDig;
  logic              loFix;
  logic              hiFix;

  // carry-in only matters for the with-carry forms
  assign cinEff = (op == OP_ADC || op == OP_SBB) ? cin : 1'b0;

  assign addW = {1'b0, t2} + {1'b0, t1} + {{DATA_W{1'b0}}, cinEff};
  assign subW = {1'b0, t2} - {1'b0, t1} - {{DATA_W{1'b0}}, cinEff};
  assign addN = {1'b0, t2[NIB_W-1:0]} + {1'b0, t1[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinEff};
  assign subN = {1'b0, t2[NIB_W-1:0]} - {1'b0, t1[NIB_W-1:0]} - {{NIB_W{1'b0}}, cinEff};

  // decimal correction derived from T1 and current flags
  assign loDig = t1[NIB_W-1:0];
  assign hiDig = t1[DATA_W-1:NIB_W];
  assign loFix = (int'(loDig) > DIGIT_MAX) || acNow;
  assign hiFix = (int'(hiDig) > DIGIT_MAX) || cyNow ||
                 ((int'(hiDig) >= DIGIT_MAX) && (int'(loDig) > DIGIT_MAX));
  assign corrOut = (loFix ? ADJ_LO : '0) | (hiFix ? ADJ_HI : '0);
  assign corrCy  = hiFix;

  assign daaW = {1'b0, t1} + {1'b0, daaAdj};
  assign daaN = {1'b0, t1[NIB_W-1:0]} + {1'b0, daaAdj[NIB_W-1:0]};

  always_comb begin
    res   = t1;
    cyOut = cyNow;
    acOut = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res   = addW[DATA_W-1:0];
        cyOut = addW[DATA_W];
        acOut = addN[NIB_W];
      end
      OP_SUB, OP_SBB: begin
        res   = subW[DATA_W-1:0];
        cyOut = subW[DATA_W];
        acOut = subN[NIB_W];
      end
      OP_AND: begin
        res   = t2 & t1;
        cyOut = 1'b0;
      end
      OP_XOR: begin
        res   = t2 ^ t1;
        cyOut = 1'b0;
      end
      OP_OR: begin
        res   = t2 | t1;
        cyOut = 1'b0;
      end
      OP_NOT: begin
        res = ~t1;
      end
      OP_DAA: begin
        if (daaApply) begin
          res   = daaW[DATA_W-1:0];
          cyOut = cyNow | daaCy;
          acOut = daaN[NIB_W];
        end else begin
          acOut = acNow;
        end
      end
      OP_RLC: begin
        res   = {t1[DATA_W-2:0], t1[DATA_W-1]};
        cyOut = t1[DATA_W-1];
      end
      OP_RRC: begin
        res   = {t1[0], t1[DATA_W-1:1]};
        cyOut = t1[0];
      end
      OP_RAL: begin
        res   = {t1[DATA_W-2:0], cyNow};
        cyOut = t1[DATA_W-1];
      end
      OP_RAR: begin
        res   = {cyNow, t1[DATA_W-1:1]};
        cyOut = t1[0];
      end
      OP_CMC: begin
        cyOut = ~cyNow;
        acOut = acNow;
      end
      OP_STC: begin
        cyOut = 1'b1;
        acOut = acNow;
      end
      default: begin
        res = t1;
      end
    endcase
  end

  assign sgnOut  = res[DATA_W-1];
  assign zeroOut = (res == '0);
  assign parOut  = ~^res;

endmodule

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic [GRP_W-1:0] flagGrp,
  input  logic             useAux,
  input  logic             setAux,
  output aluStrobe_t       strobe
);

  aluOp_e   opE;
  flagGrp_e grpE;
  logic     daaArmed;
  logic     carryOnly;
  logic     isArith;
  logic     daaFirst;
  logic     grpMain;
  logic     grpCy;

  assign opE       = aluOp_e'(opCode);
  assign grpE      = flagGrp_e'(flagGrp);
  assign carryOnly = (opE == OP_CMC) || (opE == OP_STC);
  assign isArith   = (opE == OP_ADD) || (opE == OP_ADC) ||
                     (opE == OP_SUB) || (opE == OP_SBB);
  assign daaFirst  = (opE == OP_DAA) && !daaArmed;
  assign grpMain   = (grpE == FG_R) || (grpE == FG_RC);
  assign grpCy     = (grpE == FG_C) || (grpE == FG_RC);

  // decimal adjust pairing: armed only directly after a first-phase issue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      daaArmed <= 1'b0;
    end else if (opValid) begin
      daaArmed <= daaFirst;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.op       = opE;
    strobe.cinSel   = useAux ? (setAux ? CIN_ONE : CIN_CHAIN) : CIN_FLAG;
    if (opValid) begin
      strobe.wrRes    = !carryOnly;
      strobe.wrMain   = grpMain && !carryOnly && !daaFirst;
      strobe.wrCy     = carryOnly || (grpCy && !daaFirst);
      strobe.wrChain  = useAux && isArith;
      strobe.daaLatch = daaFirst;
      strobe.daaApply = (opE == OP_DAA) && daaArmed;
    end
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opndIn,
  input  logic              loadT1,
  input  logic              loadT2,
  input  logic              clrT1,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  logic [DATA_W-1:0] t1Reg;
  logic [DATA_W-1:0] t2Reg;
  logic [DATA_W-1:0] resReg;
  logic [FLAG_W-1:0] flagReg;
  logic              chainCy;
  logic [DATA_W-1:0] daaAdjReg;
  logic              daaCyReg;

  logic              cinMux;
  logic [DATA_W-1:0] coreRes;
  logic              coreCy;
  logic              coreAc;
  logic              coreSgn;
  logic              coreZero;
  logic              corePar;
  logic [DATA_W-1:0] coreCorr;
  logic              coreCorrCy;

  always_comb begin
    unique case (strobe.cinSel)
      CIN_CHAIN: cinMux = chainCy;
      CIN_ONE:   cinMux = 1'b1;
      default:   cinMux = flagReg[F_CY];
    endcase
  end

  alu8_core u_core (
    .t1       (t1Reg),
    .t2       (t2Reg),
    .cin      (cinMux),
    .cyNow    (flagReg[F_CY]),
    .acNow    (flagReg[F_AC]),
    .op       (strobe.op),
    .daaApply (strobe.daaApply),
    .daaAdj   (daaAdjReg),
    .daaCy    (daaCyReg),
    .res      (coreRes),
    .cyOut    (coreCy),
    .acOut    (coreAc),
    .sgnOut   (coreSgn),
    .zeroOut  (coreZero),
    .parOut   (corePar),
    .corrOut  (coreCorr),
    .corrCy   (coreCorrCy)
  );

  // operand registers; clear wins over load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1Reg <= '0;
      t2Reg <= '0;
    end else begin
      if (clrT1) begin
        t1Reg <= '0;
      end else if (loadT1) begin
        t1Reg <= opndIn;
      end
      if (loadT2) begin
        t2Reg <= opndIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg    <= '0;
      flagReg   <= '0;
      chainCy   <= 1'b0;
      daaAdjReg <= '0;
      daaCyReg  <= 1'b0;
    end else begin
      if (strobe.wrRes) begin
        resReg <= coreRes;
      end
      if (strobe.wrMain) begin
        flagReg[F_S]  <= coreSgn;
        flagReg[F_Z]  <= coreZero;
        flagReg[F_AC] <= coreAc;
        flagReg[F_P]  <= corePar;
      end
      if (strobe.wrCy) begin
        flagReg[F_CY] <= coreCy;
      end
      if (strobe.wrChain) begin
        chainCy <= coreCy;
      end
      if (strobe.daaLatch) begin
        daaAdjReg <= coreCorr;
        daaCyReg  <= coreCorrCy;
      end
    end
  end

  assign result = resReg;
  assign flags  = flagReg;

endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] opndIn,
  input  logic       loadT1,
  input  logic       loadT2,
  input  logic       clrT1,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [1:0] flagGrp,
  input  logic       useAux,
  input  logic       setAux,
  output logic [7:0] result,
  output logic [4:0] flags
);

  aluStrobe_t strobe;

  alu8_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .flagGrp (flagGrp),
    .useAux  (useAux),
    .setAux  (setAux),
    .strobe  (strobe)
  );

  alu8_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opndIn (opndIn),
    .loadT1 (loadT1),
    .loadT2 (loadT2),
    .clrT1  (clrT1),
    .strobe (strobe),
    .result (result),
    .flags  (flags)
  );

endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [1:0] flagGrp,
  input logic [7:0] result,
  input logic [4:0] flags
);

  logic carryOp;
  assign carryOp = (opCode == OP_CMC) || (opCode == OP_STC);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(result) && $stable(flags)));

  assert_grp_none_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagGrp == FG_NONE && !carryOp) |=> $stable(flags));

  assert_grp_r_keeps_cy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagGrp == FG_R && !carryOp) |=> $stable(flags[F_CY]));

  assert_grp_c_keeps_main_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && flagGrp == FG_C) |=> $stable(flags[F_S:F_P]));

  assert_stc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STC) |=> (flags[F_CY] && $stable(result)));

  assert_cmc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMC) |=> (flags[F_CY] != $past(flags[F_CY]) && $stable(result)));

  assert_flag_consistency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (flagGrp == FG_R || flagGrp == FG_RC) && !carryOp && opCode != OP_DAA)
    |=> (flags[F_Z] == (result == 8'h00) && flags[F_P] == ~^result && flags[F_S] == result[7]));

endmodule

bind alu8_flagged alu8_flagged_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .flagGrp (flagGrp),
  .result  (result),
  .flags   (flags)
);

// File: tb/sim_alu8_flagged.sv
`timescale 1ns/1ps
module sim_alu8_flagged;
  import alu8_pkg::*;

  localparam real HALF_NS = 10.0;
  localparam int  VEC_N   = 12;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opndIn = '0;
  logic       loadT1 = 1'b0;
  logic       loadT2 = 1'b0;
  logic       clrT1 = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [1:0] flagGrp = '0;
  logic       useAux = 1'b0;
  logic       setAux = 1'b0;
  logic [7:0] result;
  logic [4:0] flags;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  always #(HALF_NS) clk = ~clk;

  alu8_flagged u0 (
    .clk(clk), .rstN(rstN), .opndIn(opndIn), .loadT1(loadT1), .loadT2(loadT2),
    .clrT1(clrT1), .opValid(opValid), .opCode(opCode), .flagGrp(flagGrp),
    .useAux(useAux), .setAux(setAux), .result(result), .flags(flags)
  );

  // entry: op(4) cin(1) t1(8) t2(8) expected result(8) expected flags S,Z,AC,P,CY(5)
  localparam logic [33:0] VEC [VEC_N] = '{
    {4'(OP_ADD), 1'b0, 8'hC6, 8'h3A, 8'h00, 5'b01111},
    {4'(OP_ADC), 1'b1, 8'h20, 8'h10, 8'h31, 5'b00000},
    {4'(OP_SUB), 1'b0, 8'h07, 8'h05, 8'hFE, 5'b10101},
    {4'(OP_SBB), 1'b1, 8'h10, 8'h40, 8'h2F, 5'b00100},
    {4'(OP_AND), 1'b1, 8'h3C, 8'hF0, 8'h30, 5'b00010},
    {4'(OP_XOR), 1'b1, 8'hFF, 8'hFF, 8'h00, 5'b01010},
    {4'(OP_OR),  1'b0, 8'h01, 8'h80, 8'h81, 5'b10010},
    {4'(OP_NOT), 1'b1, 8'h55, 8'h00, 8'hAA, 5'b10011},
    {4'(OP_RLC), 1'b0, 8'h81, 8'h00, 8'h03, 5'b00011},
    {4'(OP_RAR), 1'b1, 8'h01, 8'h00, 8'h80, 5'b10001},
    {4'(OP_RRC), 1'b1, 8'h02, 8'h00, 8'h01, 5'b00000},
    {4'(OP_RAL), 1'b0, 8'h80, 8'h00, 8'h00, 5'b01011}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ldT1(input logic [7:0] v);
    @(negedge clk);
    opndIn = v; loadT1 = 1'b1;
    @(negedge clk);
    loadT1 = 1'b0;
  endtask

  task automatic ldT2(input logic [7:0] v);
    @(negedge clk);
    opndIn = v; loadT2 = 1'b1;
    @(negedge clk);
    loadT2 = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] grp,
                       input logic aux, input logic setA);
    @(negedge clk);
    opValid = 1'b1; opCode = op; flagGrp = grp; useAux = aux; setAux = setA;
    @(negedge clk);
    opValid = 1'b0; useAux = 1'b0; setAux = 1'b0;
  endtask

  task automatic setCarry(input logic b);
    issue(OP_STC, FG_NONE, 1'b0, 1'b0);
    if (!b) issue(OP_CMC, FG_NONE, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset result", result, 8'h00);
    check("R1 reset flags", {3'b0, flags}, 8'h00);

    // table walk, all flags written
    for (int i = 0; i < VEC_N; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      tag = (v[33:30] <= 4'd3) ? "R3" : ((v[33:30] <= 4'd7) ? "R4" : "R5");
      setCarry(v[29]);
      ldT1(v[28:21]);
      ldT2(v[20:13]);
      issue(v[33:30], FG_RC, 1'b0, 1'b0);
      check($sformatf("%s vec%0d result", tag, i), result, v[12:5]);
      check($sformatf("R6 vec%0d flags", i), {3'b0, flags}, {3'b0, v[4:0]});
    end

    // 16-bit increment of 0x00FF through the chain carry
    setCarry(1'b0);
    ldT1(8'hFF); ldT2(8'h00);
    issue(OP_ADC, FG_R, 1'b1, 1'b1);
    check("R9 inc low byte", result, 8'h00);
    check("R7 group r keeps carry", {3'b0, flags}, {3'b0, 5'b01110});
    ldT1(8'h00);
    issue(OP_ADC, FG_NONE, 1'b1, 1'b0);
    check("R9 inc high byte", result, 8'h01);
    check("R7 group none", {3'b0, flags}, {3'b0, 5'b01110});

    // 16-bit decrement of 0x0100
    ldT2(8'h00);
    issue(OP_SBB, FG_NONE, 1'b1, 1'b1);
    check("R9 dec low byte", result, 8'hFF);
    ldT2(8'h01);
    issue(OP_SBB, FG_NONE, 1'b1, 1'b0);
    check("R9 dec high byte", result, 8'h00);
    check("R9 flags untouched", {3'b0, flags}, {3'b0, 5'b01110});

    // group c writes only carry
    ldT1(8'h81); ldT2(8'h80);
    issue(OP_ADD, FG_C, 1'b0, 1'b0);
    check("R3 group c sum", result, 8'h01);
    check("R7 group c flags", {3'b0, flags}, {3'b0, 5'b01111});

    // complement carry: result held, only carry changes
    issue(OP_CMC, FG_RC, 1'b0, 1'b0);
    check("R8 cmc result", result, 8'h01);
    check("R8 cmc flags", {3'b0, flags}, {3'b0, 5'b01110});

    ldT1(8'h01); ldT2(8'hFF);
    issue(OP_ADD, FG_R, 1'b0, 1'b0);
    check("R7 group r result", result, 8'h00);
    check("R7 group r flags", {3'b0, flags}, {3'b0, 5'b01110});

    issue(OP_STC, FG_NONE, 1'b0, 1'b0);
    check("R8 stc result", result, 8'h00);
    check("R8 stc flags", {3'b0, flags}, {3'b0, 5'b01111});

    ldT1(8'h10);
    issue(OP_ADD, FG_NONE, 1'b0, 1'b0);
    check("R7 none result", result, 8'h0F);
    check("R7 none flags", {3'b0, flags}, {3'b0, 5'b01111});

    // idle cycles hold everything
    repeat (3) @(negedge clk);
    check("R11 idle result", result, 8'h0F);
    check("R11 idle flags", {3'b0, flags}, {3'b0, 5'b01111});

    // clear wins over load
    ldT2(8'h5A);
    @(negedge clk);
    opndIn = 8'h77; loadT1 = 1'b1; clrT1 = 1'b1;
    @(negedge clk);
    loadT1 = 1'b0; clrT1 = 1'b0;
    issue(OP_AND, FG_RC, 1'b0, 1'b0);
    check("R2 clear T1 result", result, 8'h00);
    check("R2 clear T1 flags", {3'b0, flags}, {3'b0, 5'b01010});

    // operation sees T1 from before the edge that reloads it
    ldT1(8'h3C);
    @(negedge clk);
    opndIn = 8'hC3; loadT1 = 1'b1;
    opValid = 1'b1; opCode = OP_PASS; flagGrp = FG_NONE;
    @(negedge clk);
    loadT1 = 1'b0; opValid = 1'b0;
    check("R2 old operand used", result, 8'h3C);
    issue(OP_PASS, FG_NONE, 1'b0, 1'b0);
    check("R2 new operand loaded", result, 8'hC3);

    // decimal adjust of 0x9B with both carries clear
    ldT1(8'h9B); ldT2(8'hFF);
    issue(OP_AND, FG_RC, 1'b0, 1'b0);
    check("R4 and prep flags", {3'b0, flags}, {3'b0, 5'b10000});
    issue(OP_DAA, FG_RC, 1'b0, 1'b0);
    check("R10 first phase result", result, 8'h9B);
    check("R10 first phase flags", {3'b0, flags}, {3'b0, 5'b10000});
    issue(OP_DAA, FG_RC, 1'b0, 1'b0);
    check("R10 second phase result", result, 8'h01);
    check("R10 second phase flags", {3'b0, flags}, {3'b0, 5'b00101});

    // adjust after a half-carry, with a cancelled pairing first
    ldT1(8'h09); ldT2(8'h09);
    issue(OP_ADD, FG_RC, 1'b0, 1'b0);
    check("R3 half carry flags", {3'b0, flags}, {3'b0, 5'b00110});
    ldT1(8'h12);
    issue(OP_DAA, FG_RC, 1'b0, 1'b0);
    issue(OP_PASS, FG_NONE, 1'b0, 1'b0);
    issue(OP_DAA, FG_RC, 1'b0, 1'b0);
    check("R10 cancelled result", result, 8'h12);
    check("R10 cancelled flags", {3'b0, flags}, {3'b0, 5'b00110});
    issue(OP_DAA, FG_RC, 1'b0, 1'b0);
    check("R10 low digit fix result", result, 8'h18);
    check("R10 low digit fix flags", {3'b0, flags}, {3'b0, 5'b00010});

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule